// File: doc/BRIEF.md
# Dual-Mode FSK Serial Data Interface

This block connects a demodulated FSK bit line to a host microcontroller. A mode pin picks one of two behaviours. In transparent mode the incoming bit line is wired straight to the data pin. The host then decodes the asynchronous framing itself, and its clock input has no effect. In buffered mode the block finds each asynchronous start bit on a 16x oversampling tick and discards it. It samples the eight data bits and the stop bit at their centres and keeps those nine bits together in a buffer. It then pulls an active-low ready pin low. The host reads the word by toggling its own data clock. Each synchronized rising edge places the next buffered bit on the data pin: the eight data bits first, least significant first, and then the stop bit so the host can check the framing.

The block also decodes a power-down condition from the control pins. While that condition holds, the receiver and the buffer keep their state and both outputs sit at their idle level. There is no back-pressure from the host. A word that is still unread when the next start bit is confirmed is given up, and the new word replaces it. The host must finish nine clock pulses within one character time.

Top module: `fsk_serial_port`

## Requirements
- R1: With `mode_sel` = 0, `data_out` equals `fsk_bit` in the same cycle, and pulses on `host_clk` have no effect on it.
- R2: With `mode_sel` = 1, a start bit is a 1-to-0 change of `fsk_bit` seen on an `os_tick`. It is confirmed only if `fsk_bit` is still 0 on the 8th following tick. A low pulse that has ended by that tick starts no word.
- R3: After a confirmed start, data bit k (k = 0..7, least significant first) is sampled 16·(k+1) ticks after the confirmation, and the stop bit 144 ticks after it. The byte and the stop bit are stored together as one 9-bit word.
- R4: `ready_n` goes low in the cycle after the clock edge on which the stop bit is sampled.
- R5: While `ready_n` is low, each rising edge of `host_clk` puts the next buffered bit on `data_out`. The order is data bit 0 through data bit 7, and then the stop bit. The bit appears after the third clock edge that follows the `host_clk` rise, because of the two-flop synchronizer plus one register. Between a word being stored and the first pulse, `data_out` is 1.
- R6: The 9th pulse puts the stop bit on `data_out`, so a stop bit of 0 appears as 0, and it releases `ready_n` to 1.
- R7: When `mode_sel` = 1 and `ctl_a` = `ctl_b` = 0, `pwr_down` is 1. In that state `data_out` = 1 and `ready_n` = 1, and the receiver and the buffer hold their state. When the condition ends, an unread word is presented again.
- R8: Confirming a new start bit releases `ready_n`. The word that completes next overwrites the buffer.
- R9: A `host_clk` pulse while `ready_n` is high leaves `data_out` unchanged.
- R10: After reset, `ready_n` = 1. In buffered mode `data_out` = 1 and the buffer is empty.
- R11: With `mode_sel` = 0, the receiver and the buffer are cleared and `ready_n` = 1. Returning to `mode_sel` = 1 starts with no word pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsk_bit | input | 1 | Demodulated serial bit, synchronous to clk |
| os_tick | input | 1 | One-cycle strobe at 16 times the baud rate |
| mode_sel | input | 1 | 0 = transparent, 1 = buffered |
| ctl_a | input | 1 | Control pin, used in power-down decode |
| ctl_b | input | 1 | Control pin, used in power-down decode |
| host_clk | input | 1 | Host data clock, asynchronous |
| data_out | output | 1 | Serial data to the host |
| ready_n | output | 1 | Active-low word-ready |
| pwr_down | output | 1 | Power-down state flag |

## Verification
The bench sends a short low glitch that ends before mid-bit. A design without start confirmation would build a word of garbage out of it and pull `ready_n` low. It sends a word with a zero stop bit. A design that drops the stop bit or shifts only eight bits would give the host no way to see the framing error. It sends a second word before the first is read. A design that never releases ready on a new start would leave the host reading a buffer that is being replaced. It also enters power-down while a word is pending, pulses `host_clk` with no word pending, and switches to transparent mode and back. These steps catch a design that loses the buffer, shifts bits without a word pending, or leaves a stale word ready.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsk_deframer.sv
module fsk_deframer
  import fsk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hold,
  input  logic              tick,
  input  logic              rx,
  output logic              start_det,
  output logic              word_done,
  output logic [DATA_W:0]   word_bits
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOP  = BW'(DATA_W - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              prev_rx;
  logic              step;

  assign step      = tick & ~hold & ~clr;
  assign start_det = step & (state == RX_START) & (cnt == HALF) & ~rx;
  assign word_done = step & (state == RX_STOP) & (cnt == LAST);
  assign word_bits = {rx, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      prev_rx <= 1'b1;
    end else if (clr) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      prev_rx <= 1'b1;
    end else if (step) begin
      prev_rx <= rx;
      unique case (state)
        RX_IDLE: begin
          if (prev_rx && !rx) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == HALF) begin
            cnt  <= '0;
            bitn <= '0;
            state <= rx ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == LAST) begin
            cnt         <= '0;
            shreg[bitn] <= rx;
            if (bitn == TOP) state <= RX_STOP;
            else             bitn  <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsk_shiftout.sv
module fsk_shiftout #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hold,
  input  logic            load,
  input  logic [DATA_W:0] load_word,
  input  logic            cancel,
  input  logic            step,
  output logic            ready,
  output logic            pin
);
  localparam int BITS = DATA_W + 1;
  localparam int IW   = $clog2(BITS + 1);
  localparam logic [IW-1:0] LAST = IW'(BITS - 1);

  logic [BITS-1:0] wbuf;
  logic [IW-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf  <= '0;
      idx   <= '0;
      ready <= 1'b0;
      pin   <= 1'b1;
    end else if (clr) begin
      wbuf  <= '0;
      idx   <= '0;
      ready <= 1'b0;
      pin   <= 1'b1;
    end else if (!hold) begin
      if (load) begin
        wbuf  <= load_word;
        idx   <= '0;
        ready <= 1'b1;
        pin   <= 1'b1;
      end else if (cancel) begin
        ready <= 1'b0;
      end else if (step && ready) begin
        pin <= wbuf[idx];
        idx <= idx + 1'b1;
        if (idx == LAST) ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsk_serial_port.sv
module fsk_serial_port #(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsk_bit,
  input  logic os_tick,
  input  logic mode_sel,
  input  logic ctl_a,
  input  logic ctl_b,
  input  logic host_clk,
  output logic data_out,
  output logic ready_n,
  output logic pwr_down
);
  logic            host_rise;
  logic            start_det;
  logic            word_done;
  logic [DATA_W:0] word_bits;
  logic            buf_ready;
  logic            buf_pin;
  logic            rx_clr;

  assign pwr_down = mode_sel & ~ctl_a & ~ctl_b;
  assign rx_clr   = ~mode_sel;

  fsk_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (host_clk),
    .rise     (host_rise)
  );

  fsk_deframer #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .hold      (pwr_down),
    .tick      (os_tick),
    .rx        (fsk_bit),
    .start_det (start_det),
    .word_done (word_done),
    .word_bits (word_bits)
  );

  fsk_shiftout #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .hold      (pwr_down),
    .load      (word_done),
    .load_word (word_bits),
    .cancel    (start_det),
    .step      (host_rise),
    .ready     (buf_ready),
    .pin       (buf_pin)
  );

  always_comb begin
    if (!mode_sel)     data_out = fsk_bit;
    else if (pwr_down) data_out = 1'b1;
    else               data_out = buf_pin;
  end

  assign ready_n = ~(buf_ready & mode_sel & ~pwr_down);
endmodule

// File: rtl/fsk_serial_port_chk.sv
module fsk_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_sel,
  input logic pwr_down,
  input logic data_out,
  input logic ready_n,
  input logic word_done,
  input logic start_det,
  input logic host_rise
);
  // R11
  mode0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |=> ready_n);

  // R7
  pd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && $past(pwr_down)) |-> !word_done && !start_det);

  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ready_n) && !$past(pwr_down) && $past(mode_sel)) |-> $past(word_done));

  // R9
  no_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !pwr_down && $past(mode_sel) && !$past(pwr_down)
     && $past(ready_n) && !$past(word_done)) |-> $stable(data_out));

  // R6
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_n) && mode_sel && !pwr_down && $past(mode_sel) && !$past(pwr_down))
      |-> ($past(host_rise) || $past(start_det)));
endmodule

bind fsk_serial_port fsk_serial_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .pwr_down  (pwr_down),
  .data_out  (data_out),
  .ready_n   (ready_n),
  .word_done (word_done),
  .start_det (start_det),
  .host_rise (host_rise)
);

// File: tb/fsk_serial_port_test.sv
module fsk_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BIT_CLKS   = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsk_bit = 1'b1;
  logic os_tick = 1'b0;
  logic mode_sel = 1'b1;
  logic ctl_a = 1'b1;
  logic ctl_b = 1'b0;
  logic host_clk = 1'b0;
  logic data_out, ready_n, pwr_down;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  fsk_serial_port uut (
    .clk(clk), .rst_n(rst_n), .fsk_bit(fsk_bit), .os_tick(os_tick),
    .mode_sel(mode_sel), .ctl_a(ctl_a), .ctl_b(ctl_b), .host_clk(host_clk),
    .data_out(data_out), .ready_n(ready_n), .pwr_down(pwr_down)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % TDIV;
    os_tick  = (tick_cnt == 0);
  end

  // Behavioural reference model
  bit     m_active, m_prev, m_rdy, m_pin;
  int     m_t, m_idx;
  bit [8:0] m_word, m_buf;
  bit [2:0] m_hist;

  always @(posedge clk or negedge rst_n) begin
    bit load, cancel, rise, pd;
    if (!rst_n) begin
      m_active = 0; m_prev = 1; m_rdy = 0; m_pin = 1; m_t = 0; m_idx = 0;
      m_word = '0; m_buf = '0; m_hist = '0;
    end else begin
      rise   = m_hist[1] && !m_hist[2];
      m_hist = {m_hist[1:0], host_clk};
      pd     = mode_sel && !ctl_a && !ctl_b;
      load   = 0;
      cancel = 0;
      if (!mode_sel) begin
        m_active = 0; m_prev = 1; m_rdy = 0; m_pin = 1; m_idx = 0;
        m_word = '0; m_buf = '0;
      end else if (!pd) begin
        if (os_tick) begin
          if (!m_active) begin
            if (m_prev && !fsk_bit) begin m_active = 1; m_t = 0; end
          end else begin
            m_t++;
            if (m_t == 8) begin
              if (fsk_bit) m_active = 0; else cancel = 1;
            end else if (m_t > 8 && (m_t - 8) % 16 == 0) begin
              if ((m_t - 8) / 16 <= 8) m_word[(m_t - 8) / 16 - 1] = fsk_bit;
              if ((m_t - 8) / 16 == 9) begin
                m_word[8] = fsk_bit; load = 1; m_active = 0;
              end
            end
          end
          m_prev = fsk_bit;
        end
        if (load) begin
          m_buf = m_word; m_idx = 0; m_rdy = 1; m_pin = 1;
        end else if (cancel) begin
          m_rdy = 0;
        end else if (rise && m_rdy) begin
          m_pin = m_buf[m_idx];
          if (m_idx == 8) m_rdy = 0;
          m_idx++;
        end
      end
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      bit pd;
      pd = mode_sel && !ctl_a && !ctl_b;
      if (!mode_sel)
        check("R1 data_out vs model", data_out, fsk_bit);
      else if (pd)
        check("R7 data_out vs model", data_out, 1);
      else
        check("R5 data_out vs model", data_out, m_pin);
      check("R4 ready_n vs model", ready_n, !(m_rdy && mode_sel && !pd));
      check("R7 pwr_down vs model", pwr_down, pd);
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input bit [7:0] b, input bit stop, input bit chk_release);
    fsk_bit = 1'b0;
    if (chk_release) begin
      clocks(40);
      check("R8 ready released on new start", ready_n, 1);
      clocks(BIT_CLKS - 40);
    end else clocks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      fsk_bit = b[i];
      clocks(BIT_CLKS);
    end
    fsk_bit = stop;
    clocks(BIT_CLKS);
    fsk_bit = 1'b1;
    clocks(BIT_CLKS);
  endtask

  task automatic read_word(input bit [7:0] b, input bit stop);
    check("R4 ready_n low after word", ready_n, 0);
    check("R5 idle mark before first pulse", data_out, 1);
    for (int i = 0; i < 9; i++) begin
      host_clk = 1'b1;
      clocks(4);
      if (i < 8) check("R5 shifted data bit", data_out, b[i]);
      else       check("R6 shifted stop bit", data_out, stop);
      host_clk = 1'b0;
      clocks(4);
    end
    check("R6 ready released after 9th pulse", ready_n, 1);
  endtask

  initial begin
    clocks(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset data_out", data_out, 1);
    check("R10 reset ready_n", ready_n, 1);
    check("R10 reset pwr_down", pwr_down, 0);

    send_word(8'hA5, 1'b1, 1'b0);
    read_word(8'hA5, 1'b1);

    send_word(8'h3C, 1'b0, 1'b0);
    read_word(8'h3C, 1'b0);

    // R9: pulses with no word pending
    for (int i = 0; i < 3; i++) begin
      host_clk = 1'b1; clocks(4);
      host_clk = 1'b0; clocks(4);
      check("R9 data_out unchanged without word", data_out, 0);
    end

    // R2: short low glitch
    fsk_bit = 1'b0; clocks(3 * TDIV);
    fsk_bit = 1'b1; clocks(20 * BIT_CLKS / 16 + BIT_CLKS * 10);
    check("R2 glitch makes no word", ready_n, 1);

    // R8: overwrite an unread word
    send_word(8'h11, 1'b1, 1'b0);
    check("R3 first word ready", ready_n, 0);
    send_word(8'h80, 1'b1, 1'b1);
    read_word(8'h80, 1'b1);

    // R7: power-down with a word pending
    send_word(8'h5A, 1'b1, 1'b0);
    ctl_a = 1'b0;
    clocks(2);
    check("R7 pwr_down flag", pwr_down, 1);
    check("R7 data_out idle", data_out, 1);
    check("R7 ready_n idle", ready_n, 1);
    for (int i = 0; i < 2; i++) begin
      host_clk = 1'b1; clocks(4);
      host_clk = 1'b0; clocks(4);
    end
    fsk_bit = 1'b0; clocks(3 * BIT_CLKS);
    fsk_bit = 1'b1; clocks(BIT_CLKS);
    ctl_a = 1'b1;
    clocks(1);
    read_word(8'h5A, 1'b1);

    // R1 / R11: transparent mode
    send_word(8'hC3, 1'b1, 1'b0);
    mode_sel = 1'b0;
    for (int i = 0; i < 6; i++) begin
      fsk_bit  = i[0];
      host_clk = i[1];
      @(negedge clk);
      #(CLK_PERIOD/8);
      check("R1 passthrough", data_out, i[0]);
      check("R11 ready_n high in transparent mode", ready_n, 1);
    end
    fsk_bit = 1'b1; host_clk = 1'b0;
    clocks(8);
    mode_sel = 1'b1;
    clocks(2);
    check("R11 no word pending on return", ready_n, 1);
    send_word(8'h96, 1'b1, 1'b0);
    read_word(8'h96, 1'b1);

    clocks(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule